// File: doc/BRIEF.md
# Loopback and All-Ones Controller for a T1/E1 Line Channel

This block sits in the digital part of one T1/E1 line interface channel and steers dual-rail coded symbols between the system side and the line side. A two-bit selection picks one of four paths: normal, digital loopback, remote loopback, or both loopbacks together. In digital loopback, symbols from the system transmitter are sent back to the system receive outputs. In remote loopback, symbols recovered from the line are sent back out on the transmit line outputs. With both loopbacks on, both of these paths run at once. The loss-of-signal flag is always passed to the system side, whatever path is selected.

The block can also replace the transmitted line data with an all-ones pattern. Three sources request this pattern, and any one of them is enough:
- a transmit clock that stays high for longer than a set number of master-clock samples;
- a host force bit;
- an automatic trigger that fires when the auto enable bit and loss of signal are both set.

While the pattern is active, a mark is sent once every fixed number of master-clock cycles, with the polarity alternating from one mark to the next. The transmit clock plays no part in this timing.

All logic runs on the master clock. The transmit clock and the recovered clock are synchronized into the master-clock domain. Each synchronized rising edge is used as a bit strobe. Data rails are assumed stable around the rising edge of their own clock, which holds when the master clock is much faster than the bit rate.

Top module: `line_loop_ctrl`

## Requirements
- R1: With synchronous active-low reset applied and all inputs idle, every output reads 0 and the path selection is normal (code 00).
- R2: In normal mode (lb_sel = 00), a transmit symbol is written to line_pos/line_neg with a one-cycle line_stb, three master-clock edges after tclk rises. A receive symbol is written in the same way to sys_pos/sys_neg with sys_stb, on the rclk timing.
- R3: In digital loopback (lb_sel = 01), each transmit symbol is written to both the sys and the line outputs. Receive symbols leave the sys outputs unchanged and raise no sys_stb.
- R4: In remote loopback (lb_sel = 10), each receive symbol is written to both the line and the sys outputs. Transmit symbols leave the line outputs unchanged and raise no line_stb.
- R5: In dual loopback (lb_sel = 11), transmit symbols reach only the sys outputs and receive symbols reach only the line outputs.
- R6: A new lb_sel value is adopted at the next bit strobe of either clock. The symbol written at that strobe still follows the previous selection.
- R7: los_out equals los delayed by one master-clock cycle, in every mode.
- R8: The hardware all-ones request (bit 0 of lb_sel is unrelated) becomes active when the synchronized tclk has been high for more than HOLD_CYCLES consecutive samples. With tclk raised before edge 1, ones_on is 0 after edge 18 and 1 after edge 19, for HOLD_CYCLES = 16.
- R9: The hardware request clears when the first low tclk sample reaches the counter. With tclk dropped before edge 1, ones_on stays 1 after edge 2 and reads 0 after edge 3.
- R10: While ones_force is 1, ones_on is 1.
- R11: When auto_ones_en and los are both 1, ones_on is 1. Either one alone does not raise ones_on.
- R12: While ones_on is 1, the line outputs carry only marks, one every ONES_DIV master-clock cycles. Each burst starts with a positive mark (line_pos = 1) and then alternates polarity. Transmit and receive strobes do not write the line outputs during a burst.
- R13: The line outputs change only in a cycle where line_stb is 1, and the sys outputs change only in a cycle where sys_stb is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Stable master clock; all registers run on it |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk | input | 1 | System transmit bit clock; held high to request all-ones |
| tx_pos | input | 1 | Transmit positive rail from the encoder |
| tx_neg | input | 1 | Transmit negative rail from the encoder |
| rclk | input | 1 | Recovered receive bit clock |
| rx_pos | input | 1 | Recovered positive rail from the line |
| rx_neg | input | 1 | Recovered negative rail from the line |
| lb_sel | input | 2 | Path select: bit 0 digital loopback, bit 1 remote loopback |
| ones_force | input | 1 | Host all-ones request |
| auto_ones_en | input | 1 | Enables all-ones on loss of signal |
| los | input | 1 | Loss-of-signal flag from the detector |
| line_pos | output | 1 | Transmit line positive rail |
| line_neg | output | 1 | Transmit line negative rail |
| line_stb | output | 1 | One-cycle pulse when a new line symbol is written |
| sys_pos | output | 1 | Receive system positive rail |
| sys_neg | output | 1 | Receive system negative rail |
| sys_stb | output | 1 | One-cycle pulse when a new system symbol is written |
| los_out | output | 1 | Registered loss-of-signal flag |
| ones_on | output | 1 | All-ones pattern is active |

## Verification
The assertions check the following on every cycle:
- the host and automatic request sources raise ones_on;
- the hardware request clears a fixed number of cycles after a low tclk sample;
- every symbol written during a burst is a single-rail mark;
- los_out tracks los;
- neither output pair changes without its strobe.

The bench scenarios cover what a single-cycle property cannot express:
- which source reaches which output in each of the four paths;
- the one-strobe delay in adopting a new selection;
- the exact edge on which the stuck-clock count trips;
- the spacing and alternating polarity of the marks.

// File: rtl/line_loop_pkg.sv
// Shared types for the loopback and all-ones controller.
// Assumes dual-rail symbols: one bit per rail, a mark sets exactly one rail.
package line_loop_pkg;

    // Path selection; bit 0 turns on digital loopback, bit 1 remote loopback.
    typedef enum logic [1:0] {
        LB_NORMAL  = 2'b00,
        LB_DIGITAL = 2'b01,
        LB_REMOTE  = 2'b10,
        LB_DUAL    = 2'b11
    } lb_mode_e;

    // One dual-rail coded symbol.
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam rail_t RAIL_IDLE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/llc_bit_sync.sv
// Multi-stage synchronizer bringing one asynchronous level into the mclk
// domain. Assumes the input is a slow clock or level, so that metastability
// settles within the chain.
module llc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/llc_stuck_det.sv
// Counts consecutive high samples of the synchronized transmit clock and
// raises a request once the count passes HOLD. Any low sample clears the
// count, and with it the request.
module llc_stuck_det #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic req
);

    localparam int CW = $clog2(HOLD + 2);
    localparam logic [CW-1:0] FULL = CW'(HOLD + 1);

    logic [CW-1:0] run_cnt;

    // Saturating run-length count of high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !level)   run_cnt <= '0;
        else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
    end

    assign req = (run_cnt == FULL);

endmodule

// File: rtl/llc_ones_gen.sv
// All-ones pattern source timed by the master clock. It pulses stb every DIV
// cycles and presents a mark whose polarity alternates on each strobe taken
// while active. The polarity restarts positive whenever the pattern is idle.
module llc_ones_gen
    import line_loop_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    output logic  stb,
    output rail_t sym
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic phase;

    if (DIV > 1) begin : g_div
        localparam logic [DW-1:0] LAST = DW'(DIV - 1);
        logic [DW-1:0] div_cnt;

        // Free-running bit-period divider.
        always_ff @(posedge clk) begin
            if (!rst_n || div_cnt == LAST) div_cnt <= '0;
            else                           div_cnt <= div_cnt + 1'b1;
        end

        assign stb = (div_cnt == LAST);
    end else begin : g_nodiv
        assign stb = 1'b1;
    end

    // Mark polarity: toggles after each emitted mark.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) phase <= 1'b0;
        else if (stb)          phase <= ~phase;
    end

    assign sym = '{pos: ~phase, neg: phase};

endmodule

// File: rtl/line_loop_ctrl.sv
// Loopback steering and all-ones insertion for one T1/E1 channel.
// Every register runs on mclk. tclk and rclk are synchronized, and their
// rising edges serve as bit strobes. The rails of each clock are assumed
// stable around that clock's rising edge. The output registers load only
// whole symbols. The path selection is re-latched at each bit strobe.
module line_loop_ctrl
    import line_loop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16,
    parameter int ONES_DIV    = 4
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       tclk,
    input  logic       tx_pos,
    input  logic       tx_neg,
    input  logic       rclk,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic [1:0] lb_sel,
    input  logic       ones_force,
    input  logic       auto_ones_en,
    input  logic       los,
    output logic       line_pos,
    output logic       line_neg,
    output logic       line_stb,
    output logic       sys_pos,
    output logic       sys_neg,
    output logic       sys_stb,
    output logic       los_out,
    output logic       ones_on
);

    localparam int NCLK  = 2;
    localparam int TX_IX = 0;
    localparam int RX_IX = 1;

    logic [NCLK-1:0] clk_raw, clk_lvl, clk_prev, clk_rise;

    assign clk_raw = {rclk, tclk};

    for (genvar g = 0; g < NCLK; g++) begin : g_clk
        llc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (mclk),
            .rst_n    (rst_n),
            .async_in (clk_raw[g]),
            .level    (clk_lvl[g])
        );

        // Previous synchronized level, used for rising-edge detection.
        always_ff @(posedge mclk) begin
            if (!rst_n) clk_prev[g] <= 1'b0;
            else        clk_prev[g] <= clk_lvl[g];
        end

        assign clk_rise[g] = clk_lvl[g] & ~clk_prev[g];
    end

    logic tx_rise, rx_rise;
    assign tx_rise = clk_rise[TX_IX];
    assign rx_rise = clk_rise[RX_IX];

    rail_t tx_sym, rx_sym;
    assign tx_sym = '{pos: tx_pos, neg: tx_neg};
    assign rx_sym = '{pos: rx_pos, neg: rx_neg};

    // All-ones request sources.
    logic hw_req;

    llc_stuck_det #(.HOLD(HOLD_CYCLES)) u_stuck (
        .clk   (mclk),
        .rst_n (rst_n),
        .level (clk_lvl[TX_IX]),
        .req   (hw_req)
    );

    assign ones_on = hw_req | ones_force | (auto_ones_en & los);

    logic  ones_stb;
    rail_t ones_sym;

    llc_ones_gen #(.DIV(ONES_DIV)) u_ones (
        .clk    (mclk),
        .rst_n  (rst_n),
        .active (ones_on),
        .stb    (ones_stb),
        .sym    (ones_sym)
    );

    // Path selection, adopted only on a bit strobe.
    lb_mode_e mode_q;

    always_ff @(posedge mclk) begin
        if (!rst_n)                mode_q <= LB_NORMAL;
        else if (tx_rise | rx_rise) mode_q <= lb_mode_e'(lb_sel);
    end

    logic tx_to_sys, rx_to_line;
    assign tx_to_sys  = (mode_q == LB_DIGITAL) || (mode_q == LB_DUAL);
    assign rx_to_line = (mode_q == LB_REMOTE)  || (mode_q == LB_DUAL);

    // Line side: pick the source and the strobe that writes it.
    logic  line_wr;
    rail_t line_nxt;

    always_comb begin
        if (ones_on) begin
            line_wr  = ones_stb;
            line_nxt = ones_sym;
        end else if (rx_to_line) begin
            line_wr  = rx_rise;
            line_nxt = rx_sym;
        end else begin
            line_wr  = tx_rise;
            line_nxt = tx_sym;
        end
    end

    // System side: pick the source and the strobe that writes it.
    logic  sys_wr;
    rail_t sys_nxt;

    always_comb begin
        if (tx_to_sys) begin
            sys_wr  = tx_rise;
            sys_nxt = tx_sym;
        end else begin
            sys_wr  = rx_rise;
            sys_nxt = rx_sym;
        end
    end

    rail_t line_q, sys_q;
    logic  line_stb_q, sys_stb_q, los_q;

    // Output registers: load whole symbols and pulse the matching strobe.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            line_q     <= RAIL_IDLE;
            sys_q      <= RAIL_IDLE;
            line_stb_q <= 1'b0;
            sys_stb_q  <= 1'b0;
            los_q      <= 1'b0;
        end else begin
            if (line_wr) line_q <= line_nxt;
            if (sys_wr)  sys_q  <= sys_nxt;
            line_stb_q <= line_wr;
            sys_stb_q  <= sys_wr;
            los_q      <= los;
        end
    end

    assign line_pos = line_q.pos;
    assign line_neg = line_q.neg;
    assign sys_pos  = sys_q.pos;
    assign sys_neg  = sys_q.neg;
    assign line_stb = line_stb_q;
    assign sys_stb  = sys_stb_q;
    assign los_out  = los_q;

endmodule

// File: rtl/line_loop_ctrl_chk.sv
// Property checker for line_loop_ctrl, bound to every instance of it.
// Assumes the default synchronizer depth of two stages.
module line_loop_ctrl_chk (
    input logic mclk,
    input logic rst_n,
    input logic tclk,
    input logic ones_force,
    input logic auto_ones_en,
    input logic los,
    input logic los_out,
    input logic ones_on,
    input logic line_pos,
    input logic line_neg,
    input logic line_stb,
    input logic sys_pos,
    input logic sys_neg,
    input logic sys_stb,
    input logic hw_req
);

    assert_flag_delay_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        los |=> los_out);

    assert_flag_clear_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        !los |=> !los_out);

    assert_hw_clear_R9: assert property (@(posedge mclk) disable iff (!rst_n)
        !tclk |=> ##2 !hw_req);

    assert_hw_source_R8: assert property (@(posedge mclk) disable iff (!rst_n)
        hw_req |-> ones_on);

    assert_force_R10: assert property (@(posedge mclk) disable iff (!rst_n)
        ones_force |-> ones_on);

    assert_auto_R11: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_ones_en && los) |-> ones_on);

    assert_mark_only_R12: assert property (@(posedge mclk) disable iff (!rst_n)
        (line_stb && $past(ones_on)) |-> ($countones({line_pos, line_neg}) == 1));

    assert_line_hold_R13: assert property (@(posedge mclk) disable iff (!rst_n)
        !line_stb |-> $stable({line_pos, line_neg}));

    assert_sys_hold_R13: assert property (@(posedge mclk) disable iff (!rst_n)
        !sys_stb |-> $stable({sys_pos, sys_neg}));

endmodule

bind line_loop_ctrl line_loop_ctrl_chk u_chk (
    .mclk         (mclk),
    .rst_n        (rst_n),
    .tclk         (tclk),
    .ones_force   (ones_force),
    .auto_ones_en (auto_ones_en),
    .los          (los),
    .los_out      (los_out),
    .ones_on      (ones_on),
    .line_pos     (line_pos),
    .line_neg     (line_neg),
    .line_stb     (line_stb),
    .sys_pos      (sys_pos),
    .sys_neg      (sys_neg),
    .sys_stb      (sys_stb),
    .hw_req       (hw_req)
);

// File: tb/line_loop_ctrl_test.sv
// Directed bench for line_loop_ctrl: one task per scenario, each checking
// its own results. Inputs are driven and outputs sampled 1 ns after the
// falling edge of mclk.
module line_loop_ctrl_test;

    localparam int PERIOD = 10;
    localparam int DIV    = 4;
    localparam int HOLD   = 16;

    logic mclk = 1'b0, rst_n = 1'b0;
    logic tclk = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
    logic rclk = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic [1:0] lb_sel = 2'b00;
    logic ones_force = 1'b0, auto_ones_en = 1'b0, los = 1'b0;
    logic line_pos, line_neg, line_stb, sys_pos, sys_neg, sys_stb, los_out, ones_on;

    int total = 0, bad = 0;
    int line_pulses = 0, sys_pulses = 0;

    line_loop_ctrl #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .ONES_DIV(DIV)) uut (
        .mclk(mclk), .rst_n(rst_n), .tclk(tclk), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rclk(rclk), .rx_pos(rx_pos), .rx_neg(rx_neg), .lb_sel(lb_sel),
        .ones_force(ones_force), .auto_ones_en(auto_ones_en), .los(los),
        .line_pos(line_pos), .line_neg(line_neg), .line_stb(line_stb),
        .sys_pos(sys_pos), .sys_neg(sys_neg), .sys_stb(sys_stb),
        .los_out(los_out), .ones_on(ones_on)
    );

    always #(PERIOD/2) mclk = ~mclk;

    // Strobe pulse counters, sampled on the falling edge.
    always @(negedge mclk) begin
        if (line_stb) line_pulses++;
        if (sys_stb)  sys_pulses++;
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge mclk);
        #1;
    endtask

    task automatic send(bit do_tx, bit tp, bit tn, bit do_rx, bit rp, bit rn);
        if (do_tx) begin tx_pos = tp; tx_neg = tn; tclk = 1'b1; end
        if (do_rx) begin rx_pos = rp; rx_neg = rn; rclk = 1'b1; end
        tick(5);
        tclk = 1'b0;
        rclk = 1'b0;
        tick(5);
    endtask

    // Adopt a new path selection with one flush bit on the receive side.
    task automatic select(logic [1:0] code);
        lb_sel = code;
        send(0, 0, 0, 1, 0, 0);
    endtask

    // Record npulse line symbols during an all-ones burst.
    task automatic collect(string req, int npulse, bit inject);
        int seen = 0;
        int gap = 0;
        bit last_pos = 1'b0;
        for (int c = 0; c < (npulse + 2) * DIV && seen < npulse; c++) begin
            if (inject && c == 1) begin tx_pos = 1; tx_neg = 1; tclk = 1; end
            if (inject && c == 6) begin tx_pos = 0; tx_neg = 0; tclk = 0; end
            tick(1);
            if (line_stb) begin
                chk(req, "single-rail mark", int'(line_pos) + int'(line_neg), 1);
                if (seen == 0) chk(req, "first mark positive", line_pos, 1);
                else begin
                    chk(req, "alternating polarity", line_pos, !last_pos);
                    chk(req, "mark spacing", gap, DIV);
                end
                last_pos = line_pos;
                gap = 0;
                seen++;
            end
            gap++;
        end
        chk(req, "marks seen", seen, npulse);
        tclk = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "line rails", {line_pos, line_neg}, 0);
        chk("R1", "sys rails", {sys_pos, sys_neg}, 0);
        chk("R1", "strobes", {line_stb, sys_stb}, 0);
        chk("R1", "los_out", los_out, 0);
        chk("R1", "ones_on", ones_on, 0);
    endtask

    task automatic t_normal;
        int lp = line_pulses, sp = sys_pulses;
        lb_sel = 2'b00;
        send(1, 1, 0, 0, 0, 0);
        chk("R2", "tx to line", {line_pos, line_neg}, 2'b10);
        chk("R2", "line strobe count", line_pulses - lp, 1);
        chk("R2", "no sys strobe on tx", sys_pulses - sp, 0);
        send(0, 0, 0, 1, 0, 1);
        chk("R2", "rx to sys", {sys_pos, sys_neg}, 2'b01);
        chk("R2", "line kept", {line_pos, line_neg}, 2'b10);
        chk("R2", "sys strobe count", sys_pulses - sp, 1);
    endtask

    task automatic t_digital;
        int sp;
        select(2'b01);
        send(1, 0, 1, 0, 0, 0);
        chk("R3", "tx to line", {line_pos, line_neg}, 2'b01);
        chk("R3", "tx to sys", {sys_pos, sys_neg}, 2'b01);
        sp = sys_pulses;
        send(0, 0, 0, 1, 1, 0);
        chk("R3", "rx ignored on sys", {sys_pos, sys_neg}, 2'b01);
        chk("R3", "no sys strobe from rx", sys_pulses - sp, 0);
    endtask

    task automatic t_remote;
        int lp;
        select(2'b10);
        send(0, 0, 0, 1, 1, 1);
        chk("R4", "rx to line", {line_pos, line_neg}, 2'b11);
        lp = line_pulses;
        send(1, 1, 0, 0, 0, 0);
        chk("R4", "tx ignored on line", {line_pos, line_neg}, 2'b11);
        chk("R4", "no line strobe from tx", line_pulses - lp, 0);
        send(0, 0, 0, 1, 0, 1);
        chk("R4", "rx to line", {line_pos, line_neg}, 2'b01);
        chk("R4", "rx to sys", {sys_pos, sys_neg}, 2'b01);
    endtask

    task automatic t_switch;
        // Currently remote: the strobe that adopts normal still follows remote.
        lb_sel = 2'b00;
        send(0, 0, 0, 1, 1, 0);
        chk("R6", "old path at switch strobe", {line_pos, line_neg}, 2'b10);
        send(0, 0, 0, 1, 0, 1);
        chk("R6", "new path: rx not on line", {line_pos, line_neg}, 2'b10);
        chk("R6", "new path: rx on sys", {sys_pos, sys_neg}, 2'b01);
    endtask

    task automatic t_dual;
        select(2'b11);
        send(1, 1, 0, 1, 0, 1);
        chk("R5", "tx to sys", {sys_pos, sys_neg}, 2'b10);
        chk("R5", "rx to line", {line_pos, line_neg}, 2'b01);
        los = 1'b1;
        tick(2);
        chk("R7", "los_out set in dual", los_out, 1);
        chk("R7", "no all-ones without auto", ones_on, 0);
        los = 1'b0;
        tick(2);
        chk("R7", "los_out cleared", los_out, 0);
        select(2'b00);
    endtask

    task automatic t_force;
        ones_force = 1'b1;
        tick(1);
        chk("R10", "ones_on by force", ones_on, 1);
        collect("R12", 4, 1'b1);
        ones_force = 1'b0;
        tick(1);
        chk("R10", "ones_on released", ones_on, 0);
        send(1, 1, 0, 0, 0, 0);
        chk("R12", "normal data after burst", {line_pos, line_neg}, 2'b10);
    endtask

    task automatic t_auto;
        auto_ones_en = 1'b1;
        tick(1);
        chk("R11", "auto without los", ones_on, 0);
        los = 1'b1;
        tick(1);
        chk("R11", "auto with los", ones_on, 1);
        collect("R11", 2, 1'b0);
        auto_ones_en = 1'b0;
        tick(1);
        chk("R11", "los without auto", ones_on, 0);
        los = 1'b0;
        tick(2);
    endtask

    task automatic t_stuck;
        tx_pos = 0; tx_neg = 0;
        tclk = 1'b1;
        repeat (HOLD + 2) @(posedge mclk);
        #1;
        chk("R8", "not yet after 16 samples", ones_on, 0);
        @(posedge mclk);
        #1;
        chk("R8", "active after 17 samples", ones_on, 1);
        collect("R8", 3, 1'b0);
        tclk = 1'b1;
        tick(1);
        tclk = 1'b0;
        repeat (2) @(posedge mclk);
        #1;
        chk("R9", "held until low sample counted", ones_on, 1);
        @(posedge mclk);
        #1;
        chk("R9", "cleared on first low sample", ones_on, 0);
        tick(4);
    endtask

    initial begin
        #(PERIOD * 50000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_normal();
        t_digital();
        t_remote();
        t_switch();
        t_dual();
        t_force();
        t_auto();
        t_stuck();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule